// File: doc/BRIEF.md
# Single-Step State Transition Checker

This block judges whether one claimed execution step is legal. On each clock it takes a snapshot of the machine before the step (eight general registers, an instruction pointer, a sticky error-flag vector and a timestamp) and the snapshot after it. For each of a small fixed set of instruction forms it also takes a decoder verdict, a destination selector, a "writes a destination" flag, the value the form computes and the encoded length of the form. It reports which forms are satisfied and whether the step as a whole is accepted.

A form is satisfied when its decoder verdict is set and all of its own conditions hold:
- the selected destination carries the computed value;
- every other register is unchanged;
- the instruction pointer has moved forward by the form's length.

The step is accepted only when exactly one form is satisfied. The bookkeeping rules must also hold: error flags are never cleared, and the timestamp moves forward by one. Both outputs are registered, so the verdict for the inputs present at one rising edge appears right after that edge.

Top module: `step_verifier`

## Requirements
- R1: While `rst_ni` is low, `step_valid_o` and `form_ok_o` are 0, whatever the inputs.
- R2: Both outputs are registered. After a rising edge, `form_ok_o[f]` shows whether form f was satisfied by the inputs sampled at that edge. `step_valid_o` is 1 only if exactly one bit of that vector is set and the bookkeeping rules of R9 and R10 hold.
- R3: If two or more forms are satisfied in the same step, `step_valid_o` is 0 and `form_ok_o` shows every satisfied form.
- R4: If no form is satisfied, `step_valid_o` is 0.
- R5: A form whose `dec_ok_i` bit is 0 is never reported as satisfied, even if all its other conditions hold.
- R6: For a form with `has_dst_i` set, the post-step value of the selected register must equal that form's slice of `result_i`.
- R7: A register that is not the selected destination must have post value equal to pre value. When `has_dst_i` is 0 for a form, no register may change.
- R8: Selector code k (3 bits) picks register k. Register k occupies bits [32k+31:32k] of `regs_pre_i` and `regs_post_i`. Form f uses bits [3f+2:3f] of `dst_sel_i`, bits [32f+31:32f] of `result_i` and bits [4f+3:4f] of `len_i`.
- R9: Every bit set in `err_pre_i` must also be set in `err_post_i`. Raising new bits is allowed.
- R10: `ts_post_i` must equal `ts_pre_i + 1` modulo 2^32. A post value equal to the pre value, or the pre value plus 2, fails.
- R11: For form f, `ip_post_i` must equal `ip_pre_i` plus form f's length, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| regs_pre_i | input | 256 | Register file before the step, register k at bits 32k+31:32k |
| regs_post_i | input | 256 | Register file after the step |
| ip_pre_i | input | 32 | Instruction pointer before the step |
| ip_post_i | input | 32 | Instruction pointer after the step |
| err_pre_i | input | 8 | Error flags before the step |
| err_post_i | input | 8 | Error flags after the step |
| ts_pre_i | input | 32 | Timestamp before the step |
| ts_post_i | input | 32 | Timestamp after the step |
| dec_ok_i | input | 4 | Per-form decoder verdict |
| has_dst_i | input | 4 | Per-form flag: the form writes a destination register |
| dst_sel_i | input | 12 | Per-form 3-bit destination selector |
| result_i | input | 128 | Per-form computed value |
| len_i | input | 16 | Per-form 4-bit instruction length |
| form_ok_o | output | 4 | Registered per-form satisfied flags |
| step_valid_o | output | 1 | Registered verdict for the whole step |

## Verification
Two things can coincide in one cycle: a form satisfying all of its own conditions, and a bookkeeping rule being broken. The bench provokes both at once by holding a correct register, pointer and result update while it zeroes the timestamp advance or clears an error flag. The step is judged correct when `form_ok_o` still marks the form and `step_valid_o` is 0. A second overlap is two forms succeeding together. The bench drives this by setting two decode bits on identical lane inputs, and it expects both form bits set and the step rejected.

// File: rtl/step_verifier_pkg.sv
`timescale 1ns/1ps
package step_verifier_pkg;
  localparam int unsigned DEF_NUM_REGS  = 8;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NUM_FORMS = 4;
  localparam int unsigned DEF_ERR_W     = 8;
  localparam int unsigned DEF_TS_W      = 32;
  localparam int unsigned DEF_LEN_W     = 4;
endpackage

// File: rtl/sv_reg_frame.sv
`timescale 1ns/1ps
// Register-file frame rule for one form: destination carries result, rest untouched.
module sv_reg_frame #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [NUM_REGS*DATA_W-1:0] pre_i,
  input  logic [NUM_REGS*DATA_W-1:0] post_i,
  input  logic                       has_dst_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [DATA_W-1:0]          result_i,
  output logic                       frame_ok_o
);
  logic [NUM_REGS-1:0] keep_ok;
  logic [DATA_W-1:0]   dst_val;
  logic                sel_hit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] pre_w;
    logic [DATA_W-1:0] post_w;
    logic              is_dst;
    assign pre_w      = pre_i[r*DATA_W +: DATA_W];
    assign post_w     = post_i[r*DATA_W +: DATA_W];
    assign is_dst     = has_dst_i && (sel_i == SEL_W'(r));
    assign keep_ok[r] = (post_w == pre_w) || is_dst;
  end

  // selector mux over post values, encoding order
  always_comb begin
    dst_val = '0;
    sel_hit = 1'b0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (sel_i == SEL_W'(k)) begin
        dst_val = post_i[k*DATA_W +: DATA_W];
        sel_hit = 1'b1;
      end
    end
  end

  assign frame_ok_o = (&keep_ok) && (!has_dst_i || (sel_hit && (dst_val == result_i)));
endmodule

// File: rtl/sv_trace_rules.sv
`timescale 1ns/1ps
// Bookkeeping: sticky error flags, unit timestamp advance.
module sv_trace_rules #(
  parameter int unsigned ERR_W = 8,
  parameter int unsigned TS_W  = 32
) (
  input  logic [ERR_W-1:0] err_pre_i,
  input  logic [ERR_W-1:0] err_post_i,
  input  logic [TS_W-1:0]  ts_pre_i,
  input  logic [TS_W-1:0]  ts_post_i,
  output logic             trace_ok_o
);
  logic [ERR_W-1:0] cleared;
  logic [TS_W-1:0]  ts_next;
  logic             err_ok;
  logic             ts_ok;

  assign cleared    = err_pre_i & ~err_post_i;
  assign err_ok     = (cleared == '0);
  assign ts_next    = ts_pre_i + TS_W'(1);
  assign ts_ok      = (ts_post_i == ts_next);
  assign trace_ok_o = err_ok && ts_ok;
endmodule

// File: rtl/sv_once.sv
`timescale 1ns/1ps
// Exactly-one detector: population count compared against one.
module sv_once #(
  parameter int unsigned N = 4,
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic         one_o
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < N; k++) cnt = cnt + CW'(bits_i[k]);
  end

  assign one_o = (cnt == CW'(1));
endmodule

// File: rtl/step_verifier.sv
`timescale 1ns/1ps
module step_verifier
  import step_verifier_pkg::*;
#(
  parameter int unsigned NUM_REGS  = DEF_NUM_REGS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_FORMS = DEF_NUM_FORMS,
  parameter int unsigned ERR_W     = DEF_ERR_W,
  parameter int unsigned TS_W      = DEF_TS_W,
  parameter int unsigned LEN_W     = DEF_LEN_W,
  localparam int unsigned SEL_W    = $clog2(NUM_REGS),
  localparam int unsigned RF_W     = NUM_REGS * DATA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [RF_W-1:0]            regs_pre_i,
  input  logic [RF_W-1:0]            regs_post_i,
  input  logic [DATA_W-1:0]          ip_pre_i,
  input  logic [DATA_W-1:0]          ip_post_i,
  input  logic [ERR_W-1:0]           err_pre_i,
  input  logic [ERR_W-1:0]           err_post_i,
  input  logic [TS_W-1:0]            ts_pre_i,
  input  logic [TS_W-1:0]            ts_post_i,
  input  logic [NUM_FORMS-1:0]       dec_ok_i,
  input  logic [NUM_FORMS-1:0]       has_dst_i,
  input  logic [NUM_FORMS*SEL_W-1:0] dst_sel_i,
  input  logic [NUM_FORMS*DATA_W-1:0] result_i,
  input  logic [NUM_FORMS*LEN_W-1:0] len_i,
  output logic [NUM_FORMS-1:0]       form_ok_o,
  output logic                       step_valid_o
);
  logic [NUM_FORMS-1:0] form_ok_d;
  logic                 trace_ok;
  logic                 one_hit;

  for (genvar f = 0; f < NUM_FORMS; f++) begin : g_form
    logic              frame_ok;
    logic              ip_ok;
    logic [DATA_W-1:0] ip_next;

    sv_reg_frame #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .SEL_W    (SEL_W)
    ) u_frame (
      .pre_i      (regs_pre_i),
      .post_i     (regs_post_i),
      .has_dst_i  (has_dst_i[f]),
      .sel_i      (dst_sel_i[f*SEL_W +: SEL_W]),
      .result_i   (result_i[f*DATA_W +: DATA_W]),
      .frame_ok_o (frame_ok)
    );

    assign ip_next      = ip_pre_i + DATA_W'(len_i[f*LEN_W +: LEN_W]);
    assign ip_ok        = (ip_post_i == ip_next);
    assign form_ok_d[f] = dec_ok_i[f] && frame_ok && ip_ok;
  end

  sv_trace_rules #(
    .ERR_W (ERR_W),
    .TS_W  (TS_W)
  ) u_trace (
    .err_pre_i  (err_pre_i),
    .err_post_i (err_post_i),
    .ts_pre_i   (ts_pre_i),
    .ts_post_i  (ts_post_i),
    .trace_ok_o (trace_ok)
  );

  sv_once #(
    .N (NUM_FORMS)
  ) u_once (
    .bits_i (form_ok_d),
    .one_o  (one_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      form_ok_o    <= '0;
      step_valid_o <= 1'b0;
    end else begin
      form_ok_o    <= form_ok_d;
      step_valid_o <= one_hit && trace_ok;
    end
  end
endmodule

// File: rtl/step_verifier_chk.sv
`timescale 1ns/1ps
module step_verifier_chk #(
  parameter int unsigned NUM_FORMS = 4,
  parameter int unsigned ERR_W     = 8,
  parameter int unsigned TS_W      = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ERR_W-1:0]     err_pre_i,
  input logic [ERR_W-1:0]     err_post_i,
  input logic [TS_W-1:0]      ts_pre_i,
  input logic [TS_W-1:0]      ts_post_i,
  input logic [NUM_FORMS-1:0] dec_ok_i,
  input logic [NUM_FORMS-1:0] form_ok_o,
  input logic                 step_valid_o
);
  p_single_form_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> ($countones(form_ok_o) == 1));

  p_many_forms_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(form_ok_o) > 1) |-> !step_valid_o);

  p_no_form_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_ok_o == '0) |-> !step_valid_o);

  p_flag_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_pre_i & ~err_post_i) != '0) |=> !step_valid_o);

  p_ts_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_post_i != ts_pre_i + TS_W'(1)) |=> !step_valid_o);

  for (genvar f = 0; f < NUM_FORMS; f++) begin : g_dec
    p_no_decode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dec_ok_i[f] |=> !form_ok_o[f]);
  end
endmodule

bind step_verifier step_verifier_chk #(
  .NUM_FORMS (NUM_FORMS),
  .ERR_W     (ERR_W),
  .TS_W      (TS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .err_pre_i    (err_pre_i),
  .err_post_i   (err_post_i),
  .ts_pre_i     (ts_pre_i),
  .ts_post_i    (ts_post_i),
  .dec_ok_i     (dec_ok_i),
  .form_ok_o    (form_ok_o),
  .step_valid_o (step_valid_o)
);

// File: tb/sim_step_verifier.sv
`timescale 1ns/1ps
module sim_step_verifier;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] regs_pre, regs_post;
  logic [31:0]  ip_pre, ip_post, ts_pre, ts_post;
  logic [7:0]   err_pre, err_post;
  logic [3:0]   dec_ok, has_dst;
  logic [11:0]  dst_sel;
  logic [127:0] result;
  logic [15:0]  len;
  logic [3:0]   form_ok;
  logic         step_valid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  step_verifier u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .regs_pre_i (regs_pre), .regs_post_i (regs_post),
    .ip_pre_i (ip_pre), .ip_post_i (ip_post),
    .err_pre_i (err_pre), .err_post_i (err_post),
    .ts_pre_i (ts_pre), .ts_post_i (ts_post),
    .dec_ok_i (dec_ok), .has_dst_i (has_dst),
    .dst_sel_i (dst_sel), .result_i (result), .len_i (len),
    .form_ok_o (form_ok), .step_valid_o (step_valid)
  );

  function automatic logic [31:0] seed_val(int r);
    return 32'h1357_0000 + 32'(r) * 32'h0011_0203;
  endfunction

  // legal step: form 0 writes res into register sel, length 3
  task automatic set_base(int sel, logic [31:0] res);
    for (int r = 0; r < 8; r++) begin
      regs_pre[r*32 +: 32]  = seed_val(r);
      regs_post[r*32 +: 32] = seed_val(r);
    end
    regs_post[sel*32 +: 32] = res;
    dec_ok  = 4'b0001;
    has_dst = 4'b1111;
    dst_sel = {4{3'(sel)}};
    result  = {4{res}};
    len     = {4{4'd3}};
    ip_pre  = 32'h0000_4000;
    ip_post = 32'h0000_4003;
    err_pre = 8'h05;
    err_post = 8'h05;
    ts_pre  = 32'd100;
    ts_post = 32'd101;
  endtask

  task automatic judge(string tag, logic exp_v, logic [3:0] exp_f);
    n_chk++;
    if (step_valid !== exp_v || form_ok !== exp_f) begin
      n_bad++;
      $display("FAIL %s: valid=%0b forms=%b expected valid=%0b forms=%b",
               tag, step_valid, form_ok, exp_v, exp_f);
    end
  endtask

  // inputs set at negedge; verdict visible after the next rising edge
  task automatic step_check(string tag, logic exp_v, logic [3:0] exp_f);
    @(posedge clk);
    @(negedge clk);
    judge(tag, exp_v, exp_f);
  endtask

  task automatic t_reset;
    set_base(3, 32'hCAFE_0003);
    repeat (2) @(negedge clk);
    judge("R1 outputs low in reset", 1'b0, 4'b0000);
    rst_n = 1'b1;
  endtask

  task automatic t_legal;
    set_base(3, 32'hCAFE_0003);
    step_check("R2 legal move-immediate", 1'b1, 4'b0001);
  endtask

  task automatic t_sel_map;
    for (int s = 0; s < 8; s++) begin
      set_base(s, 32'hBEEF_0000 + 32'(s));
      step_check($sformatf("R8 selector %0d", s), 1'b1, 4'b0001);
    end
    set_base(2, 32'hBEEF_0002);
    regs_post[2*32 +: 32] = seed_val(2);
    regs_post[3*32 +: 32] = 32'hBEEF_0002;
    step_check("R8 value in neighbour register", 1'b0, 4'b0000);
  endtask

  task automatic t_frame;
    set_base(4, 32'hCAFE_0004);
    regs_post[1*32 +: 32] = regs_post[1*32 +: 32] ^ 32'h1;
    step_check("R7 unselected register changed", 1'b0, 4'b0000);
    set_base(4, 32'hCAFE_0004);
    has_dst = 4'b0000;
    regs_post = regs_pre;
    step_check("R7 no-destination form, nothing changed", 1'b1, 4'b0001);
    regs_post[0 +: 32] = 32'h0;
    step_check("R7 no-destination form, register changed", 1'b0, 4'b0000);
  endtask

  task automatic t_result;
    set_base(5, 32'hCAFE_0005);
    regs_post[5*32 +: 32] = 32'hCAFE_0006;
    step_check("R6 wrong destination value", 1'b0, 4'b0000);
    set_base(5, seed_val(5));
    step_check("R6 result equal to old value", 1'b1, 4'b0001);
  endtask

  task automatic t_only_once;
    set_base(1, 32'hCAFE_0001);
    dec_ok = 4'b0011;
    step_check("R3 two forms succeed", 1'b0, 4'b0011);
    dec_ok = 4'b1111;
    step_check("R3 all forms succeed", 1'b0, 4'b1111);
    dec_ok = 4'b0000;
    step_check("R4 no form decodes", 1'b0, 4'b0000);
  endtask

  task automatic t_decode;
    set_base(6, 32'hCAFE_0006);
    dec_ok = 4'b0100;
    step_check("R5 only form 2 decodes", 1'b1, 4'b0100);
  endtask

  task automatic t_err;
    set_base(0, 32'hCAFE_0000);
    err_post = 8'h07;
    step_check("R9 new flag raised", 1'b1, 4'b0001);
    err_post = 8'h04;
    step_check("R9 flag cleared, form still ok", 1'b0, 4'b0001);
  endtask

  task automatic t_ts;
    set_base(7, 32'hCAFE_0007);
    ts_post = ts_pre;
    step_check("R10 timestamp +0", 1'b0, 4'b0001);
    ts_post = ts_pre + 32'd2;
    step_check("R10 timestamp +2", 1'b0, 4'b0001);
    ts_pre = 32'hFFFF_FFFF;
    ts_post = 32'h0;
    step_check("R10 timestamp wraps", 1'b1, 4'b0001);
  endtask

  task automatic t_ip;
    set_base(2, 32'hCAFE_0002);
    ip_post = ip_pre + 32'd2;
    step_check("R11 pointer short", 1'b0, 4'b0000);
    ip_pre = 32'hFFFF_FFFE;
    ip_post = 32'h0000_0001;
    step_check("R11 pointer wraps", 1'b1, 4'b0001);
    set_base(2, 32'hCAFE_0002);
    dec_ok = 4'b0010;
    len[4 +: 4] = 4'd5;
    step_check("R11 per-form length mismatch", 1'b0, 4'b0000);
    ip_post = ip_pre + 32'd5;
    step_check("R11 per-form length match", 1'b1, 4'b0010);
  endtask

  task automatic t_overlap;
    set_base(3, 32'hCAFE_0003);
    dec_ok = 4'b0011;
    ts_post = ts_pre;
    step_check("R3 R10 double form with stalled timestamp", 1'b0, 4'b0011);
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_legal();
    t_sel_map();
    t_frame();
    t_result();
    t_only_once();
    t_decode();
    t_err();
    t_ts();
    t_ip();
    t_overlap();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule